// File: doc/BRIEF.md
# Sync-Locked Capture Coordinate Generator

This block runs on a fast local sample clock and follows an external video source that supplies only active-low horizontal and vertical sync. Both syncs are asynchronous to the sample clock. The block brings them into its own clock domain and derives a column and a row position from them. It then issues one write per pixel into a 512-entry line buffer: the write address is the column and the write data is the byte on the pixel input.

Every pixel spans eight sample clocks. The column moves on only at the eighth sub-sample, which gives the colour front end time to settle. When a line ends, a one-cycle pulse carries the number of the line just finished. A downstream mover can use it to copy the buffer out.

The row count rises on each horizontal sync release and is cleared during vertical sync. Short frames that end with rows still to come are handled normally.

Top module: `vcap_coord_gen`

## Requirements
- R1: While `rst` is high and on the first clock after its release, `col_idx`, `row_idx`, `wr_en`, `wr_addr`, `wr_data`, `eol` and `eol_row` are all zero.
- R2: Both sync inputs reach the counting logic through two sample-clock flip-flops. `row_idx` takes its new value on the third rising clock edge after `hsync_n` goes high, and not earlier.
- R3: While the synchronized `vsync_n` is low, `row_idx` is zero, including when an `hsync_n` rising edge arrives at the same time.
- R4: `col_idx` is zero while the synchronized `hsync_n` is low. While it is high, `col_idx` rises by one every eight sample clocks and then holds at 511 without wrapping.
- R5: `wr_en` is a one-cycle pulse, issued once per eight sample clocks while the synchronized `hsync_n` is high, and at most 512 times per line. With each pulse, `wr_addr` equals the column before it steps. `wr_data` is the `pix_in` byte sampled on that edge, unchanged and packed as red in bits 7:5, green in bits 4:2 and blue in bits 1:0.
- R6: `eol` is a one-cycle pulse on each falling edge of the synchronized `hsync_n`. At the same time, `eol_row` shows the `row_idx` of the line that has just ended.
- R7: `row_idx` is 9 bits wide and holds at 511 when vertical sync stays high for more than 511 lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | input | 1 | Horizontal sync, active low, asynchronous |
| vsync_n | input | 1 | Vertical sync, active low, asynchronous |
| pix_in | input | 8 | Pixel sample, RRRGGGBB |
| col_idx | output | 9 | Current column |
| row_idx | output | 9 | Current row |
| wr_en | output | 1 | Line-buffer write strobe |
| wr_addr | output | 9 | Line-buffer write address |
| wr_data | output | 8 | Line-buffer write data |
| eol | output | 1 | End-of-line pulse |
| eol_row | output | 9 | Row of the line just ended |

## Verification
A wrong sub-sample count or column value shows up on the next `wr_en`, which is never more than eight clocks away: the strobe arrives at the wrong time or with a shifted `wr_addr`. A wrong row state shows up on `row_idx` straight away, and on `eol_row` at the end of the same line. The reference model is compared with every output on every clock. An error therefore shows up in the cycle where it first reaches a port, and the long-line and many-line runs reach both saturation limits.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
    localparam int SUB_LOG    = 3;
    localparam int PIXELS     = 512;
    localparam int ROW_W      = 9;
    localparam int SYNC_DEPTH = 2;

    typedef struct packed {
        logic [2:0] red;
        logic [2:0] green;
        logic [1:0] blue;
    } rgb332_t;

    function automatic int clog2_min1(input int v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction
endpackage

// File: rtl/vcap_sync.sv
module vcap_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/vcap_col_tracker.sv
module vcap_col_tracker
    import vcap_pkg::*;
#(
    parameter int SUB_BITS = 3,
    parameter int NPIX     = 512,
    localparam int COL_W   = clog2_min1(NPIX),
    localparam int CNT_W   = COL_W + SUB_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             h_act,
    input  rgb332_t          pix,
    output logic [COL_W-1:0] col_q,
    output logic             wr_en,
    output logic [COL_W-1:0] wr_addr,
    output rgb332_t          wr_data
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [COL_W-1:0] COL_MAX = COL_W'(NPIX - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             full_q;
    logic             step;

    assign step = h_act && (&cnt_q[SUB_BITS-1:0]) && !full_q;

    always_ff @(posedge clk) begin
        if (rst || !h_act) begin
            cnt_q  <= '0;
            col_q  <= '0;
            full_q <= 1'b0;
        end else begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            if (step) begin
                full_q <= (col_q == COL_MAX);
                if (col_q != COL_MAX) col_q <= col_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= step;
            wr_addr <= col_q;
            wr_data <= pix;
        end
    end

    // R4
    col_step_chk: assert property (@(posedge clk) disable iff (rst)
        (col_q != $past(col_q)) |-> (col_q == $past(col_q) + 1'b1 || col_q == '0));

    // R5
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);
endmodule

// File: rtl/vcap_row_tracker.sv
module vcap_row_tracker #(
    parameter int RW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          v_act,
    input  logic          h_rise,
    input  logic          h_fall,
    output logic [RW-1:0] row_q,
    output logic          eol,
    output logic [RW-1:0] eol_row
);
    localparam logic [RW-1:0] ROW_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || !v_act)                    row_q <= '0;
        else if (h_rise && row_q != ROW_MAX)  row_q <= row_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eol     <= 1'b0;
            eol_row <= '0;
        end else begin
            eol <= h_fall;
            if (h_fall) eol_row <= row_q;
        end
    end

    // R3
    vsync_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !v_act |=> (row_q == '0));

    // R7
    row_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (row_q == ROW_MAX) |=> (row_q == ROW_MAX || row_q == '0));

    // R6
    eol_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eol |=> !eol);
endmodule

// File: rtl/vcap_coord_gen.sv
module vcap_coord_gen
    import vcap_pkg::*;
#(
    parameter int SUB_BITS = SUB_LOG,
    parameter int NPIX     = PIXELS,
    parameter int RW       = ROW_W,
    parameter int SYNC_N   = SYNC_DEPTH,
    localparam int COL_W   = clog2_min1(NPIX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync_n,
    input  logic             vsync_n,
    input  logic [7:0]       pix_in,
    output logic [COL_W-1:0] col_idx,
    output logic [RW-1:0]    row_idx,
    output logic             wr_en,
    output logic [COL_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             eol,
    output logic [RW-1:0]    eol_row
);
    logic [1:0] sync_v;
    logic       h_prev_q;
    logic       h_rise, h_fall;
    rgb332_t    pix_s, wr_pix;

    vcap_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst),
        .async_in({vsync_n, hsync_n}),
        .sync_out(sync_v)
    );

    always_ff @(posedge clk) begin
        if (rst) h_prev_q <= 1'b0;
        else     h_prev_q <= sync_v[0];
    end

    assign h_rise = sync_v[0] && !h_prev_q;
    assign h_fall = !sync_v[0] && h_prev_q;
    assign pix_s  = rgb332_t'(pix_in);

    vcap_col_tracker #(.SUB_BITS(SUB_BITS), .NPIX(NPIX)) u_col (
        .clk(clk), .rst(rst), .h_act(sync_v[0]), .pix(pix_s),
        .col_q(col_idx), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_pix)
    );

    assign wr_data = 8'(wr_pix);

    vcap_row_tracker #(.RW(RW)) u_row (
        .clk(clk), .rst(rst), .v_act(sync_v[1]),
        .h_rise(h_rise), .h_fall(h_fall),
        .row_q(row_idx), .eol(eol), .eol_row(eol_row)
    );

    // R6
    eol_needs_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(eol) |-> ($past(h_prev_q) && !$past(sync_v[0])));
endmodule

// File: tb/vcap_coord_gen_bench.sv
module vcap_coord_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_n = 1'b0;
    logic       vsync_n = 1'b0;
    logic [7:0] pix_in = 8'h00;
    logic [8:0] col_idx, row_idx, wr_addr, eol_row;
    logic [7:0] wr_data;
    logic       wr_en, eol;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vcap_coord_gen u_vcap_coord_gen (
        .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n), .pix_in(pix_in),
        .col_idx(col_idx), .row_idx(row_idx), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .eol(eol), .eol_row(eol_row)
    );

    // behavioural reference: sync delay, sample count, strobes per line, rows
    int h_pipe[$];
    int v_pipe[$];
    int m_hprev, m_cnt, m_done, m_row;
    int m_col, m_wr, m_addr, m_data, m_eol, m_eolrow;
    bit model_on = 1'b0;

    always @(posedge clk) begin
        int hs, vs;
        if (rst) begin
            h_pipe = '{0, 0}; v_pipe = '{0, 0};
            m_hprev = 0; m_cnt = 0; m_done = 0; m_row = 0;
            m_col = 0; m_wr = 0; m_addr = 0; m_data = 0; m_eol = 0; m_eolrow = 0;
        end else begin
            hs = h_pipe[1]; vs = v_pipe[1];
            m_eol = (m_hprev == 1 && hs == 0) ? 1 : 0;
            if (m_eol == 1) m_eolrow = m_row;
            m_wr = (hs == 1 && (m_cnt % 8) == 7 && m_done < 512) ? 1 : 0;
            m_addr = (m_done > 511) ? 511 : m_done;
            m_data = int'(pix_in);
            if (hs == 0) begin m_done = 0; m_cnt = 0; end
            else begin
                if (m_wr == 1) m_done++;
                if (m_cnt < 4095) m_cnt++;
            end
            m_col = (m_done > 511) ? 511 : m_done;
            if (vs == 0) m_row = 0;
            else if (hs == 1 && m_hprev == 0 && m_row < 511) m_row++;
            m_hprev = hs;
            h_pipe = '{int'(hsync_n), h_pipe[0]};
            v_pipe = '{int'(vsync_n), v_pipe[0]};
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !rst) begin
            check("R4 col_idx", int'(col_idx), m_col);
            check("R2/R3/R7 row_idx", int'(row_idx), m_row);
            check("R5 wr_en", int'(wr_en), m_wr);
            if (m_wr == 1) begin
                check("R5 wr_addr", int'(wr_addr), m_addr);
                check("R5 wr_data", int'(wr_data), m_data);
            end
            check("R6 eol", int'(eol), m_eol);
            if (m_eol == 1) check("R6 eol_row", int'(eol_row), m_eolrow);
        end
    end

    int wr_count = 0;
    int eol_count = 0;
    always @(negedge clk) begin
        if (wr_en) wr_count++;
        if (eol) eol_count++;
    end

    always @(negedge clk) pix_in <= 8'($urandom);

    task automatic line(input int high_cycles, input int low_cycles);
        @(negedge clk) hsync_n = 1'b1;
        repeat (high_cycles - 1) @(negedge clk);
        @(negedge clk) hsync_n = 1'b0;
        repeat (low_cycles - 1) @(negedge clk);
    endtask

    initial begin
        int r0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 col", int'(col_idx), 0);
        check("R1 row", int'(row_idx), 0);
        check("R1 wr_en", int'(wr_en), 0);
        check("R1 eol", int'(eol), 0);
        check("R1 eol_row", int'(eol_row), 0);
        rst = 1'b0;
        model_on = 1'b1;
        @(negedge clk);
        check("R1 first clock wr_en", int'(wr_en), 0);
        check("R1 first clock row", int'(row_idx), 0);

        vsync_n = 1'b1;
        repeat (6) @(negedge clk);
        // R2 latency: row changes on third edge after hsync rises
        r0 = int'(row_idx);
        hsync_n = 1'b1;
        @(negedge clk); check("R2 row after 1 edge", int'(row_idx), r0);
        @(negedge clk); check("R2 row after 2 edges", int'(row_idx), r0);
        @(negedge clk); check("R2 row after 3 edges", int'(row_idx), r0 + 1);
        repeat (40) @(negedge clk);
        hsync_n = 1'b0;
        repeat (10) @(negedge clk);

        for (int i = 0; i < 6; i++) line(60 + 13 * i, 12);

        // R4/R5 full line with saturation
        wr_count = 0;
        @(negedge clk) hsync_n = 1'b1;
        repeat (4300) @(negedge clk);
        check("R4 col saturated", int'(col_idx), 511);
        check("R5 strobes per line", wr_count, 512);
        eol_count = 0;
        hsync_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R6 one eol", eol_count, 1);
        check("R4 col cleared", int'(col_idx), 0);

        // R3 vsync low holds row zero
        vsync_n = 1'b0;
        for (int i = 0; i < 4; i++) line(30, 8);
        check("R3 row during vsync", int'(row_idx), 0);
        vsync_n = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 3; i++) line(20, 6);
        check("R3 row after vsync", int'(row_idx), 3);

        // R7 saturation with missing vsync
        for (int i = 0; i < 520; i++) line(4, 4);
        repeat (4) @(negedge clk);
        check("R7 row held at max", int'(row_idx), 511);
        vsync_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R3 row cleared", int'(row_idx), 0);
        repeat (5) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule